// File: doc/BRIEF.md
# DMA Major/Minor Loop Transfer Engine

This block carries out the transfer descriptor of a single DMA channel. It is given a source address, a destination address, signed offsets for each side, a transfer size for each side, a byte count for one minor loop, and a current and a beginning major iteration count. After an arbiter's start request is acknowledged, the engine runs one minor loop. It reads the source port in units of the source size. It packs those units little-endian into words of the destination size and writes each word to the destination port with byte enables.

Each acknowledged start runs exactly one minor loop. Between activations the engine keeps its addresses and its iteration count, and it takes up where it stopped on the next start. When the last major iteration ends, it sets a done flag. It raises an interrupt alongside done only when interrupts are enabled, and it reloads the current iteration count from the beginning count. When both counts are set to 1, the whole transfer happens in one activation.

The descriptor inputs must be held stable while a transfer is in progress. The byte count must be a non-zero multiple of the destination size. The destination size must be at least the source size.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, `busy`, `done`, `irq`, `startAck`, `rdEn` and `wrEn` are all 0 and `citer` is 0.
- R2: Neither a read nor a write is issued unless a start has been accepted. `startAck` pulses for one cycle when `startReq` is high while the engine is idle, and the first read follows in the next cycle.
- R3: Size codes are 0 for a byte, 1 for a 16-bit halfword and 2 for a 32-bit word. A source read takes its data from the low lanes of `rdData`. Consecutive reads are packed little-endian, so the first read lands in the lowest lanes. Each write drives the packed word on the low lanes of `wrData`, with exactly the low 2^dstSize bits of `wrBe` set. A read and a write are never issued in the same cycle.
- R4: The source address moves by the sign-extended source offset after every read. The destination address moves by the sign-extended destination offset after every write.
- R5: One activation moves exactly `minorBytes` bytes and then returns to idle. At the end of that minor loop the current iteration count drops by one, and the addresses carry over to the next activation.
- R6: When the current iteration count reaches zero, `done` is set and `citer` is reloaded from `biterIn`. The next start then loads a fresh descriptor.
- R7: `irq` is set together with `done` only when `intEn` is 1. `irq` is never high while `done` is low.
- R8: `done` and `irq` stay high until `doneClr` is pulsed or a new start is accepted.
- R9: With `citerIn` = `biterIn` = 1, one activation completes the whole transfer and sets `done`. For example, 16 bytes move from 0x1000 with byte reads into 32-bit writes at 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Service request from the arbiter |
| startAck | output | 1 | One-cycle acknowledge of an accepted start |
| doneClr | input | 1 | Clears done and irq |
| intEn | input | 1 | Enables the completion interrupt |
| srcAddrIn | input | ADDR_W | Descriptor source address |
| dstAddrIn | input | ADDR_W | Descriptor destination address |
| srcOff | input | OFF_W | Signed source offset |
| dstOff | input | OFF_W | Signed destination offset |
| srcSize | input | 2 | Source size code |
| dstSize | input | 2 | Destination size code |
| minorBytes | input | NB_W | Bytes moved per minor loop |
| citerIn | input | ITER_W | Current major iteration count |
| biterIn | input | ITER_W | Beginning major iteration count |
| rdEn | output | 1 | Read strobe; data is returned one cycle later |
| rdAddr | output | ADDR_W | Read address |
| rdData | input | DATA_W | Read data |
| wrEn | output | 1 | Write strobe |
| wrAddr | output | ADDR_W | Write address |
| wrData | output | DATA_W | Write data |
| wrBe | output | DATA_W/8 | Write byte enables |
| busy | output | 1 | Engine is running a minor loop |
| done | output | 1 | Major loop complete |
| irq | output | 1 | Completion interrupt |
| citer | output | ITER_W | Current iteration count |

## Verification
The hardest situation to reach is an activation that is not the last one. Here the engine must stop with its addresses held and its count decremented, then resume from that point on the next start rather than reloading the descriptor. The stimulus table includes descriptors with iteration counts of 2 and 3. Between activations the bench checks that `done` is still low and that `citer` has the expected value. It then compares the full destination image with a byte-stream model that applies the offsets across activation boundaries. Descending source offsets and a fixed destination address are included to cover sign extension and repeated overwrites.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_CAPT = 2'd2,
    ST_WRITE = 2'd3
  } engState_t;

  typedef struct packed {
    logic load;
    logic issueRd;
    logic capture;
    logic issueWr;
    logic minorEnd;
  } engStrobe_t;

endpackage

// File: rtl/dma_eng_ctrl.sv
module dma_eng_ctrl
  import dma_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       doneClr,
  input  logic       intEn,
  input  logic       packWillFill,
  input  logic       minorDone,
  input  logic       lastIter,
  output engStrobe_t strobe,
  output logic       startAck,
  output logic       busy,
  output logic       done,
  output logic       irq
);

  engState_t state, stateNxt;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    startAck = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          startAck    = 1'b1;
          strobe.load = 1'b1;
          stateNxt    = ST_READ;
        end
      end
      ST_READ: begin
        strobe.issueRd = 1'b1;
        stateNxt       = ST_CAPT;
      end
      ST_CAPT: begin
        strobe.capture = 1'b1;
        stateNxt       = packWillFill ? ST_WRITE : ST_READ;
      end
      ST_WRITE: begin
        strobe.issueWr = 1'b1;
        if (minorDone) begin
          strobe.minorEnd = 1'b1;
          stateNxt        = ST_IDLE;
        end else begin
          stateNxt = ST_READ;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strobe.minorEnd && lastIter) begin
        done <= 1'b1;
        irq  <= intEn;
      end else if (doneClr || strobe.load) begin
        done <= 1'b0;
        irq  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_eng_dpath.sv
module dma_eng_dpath
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int NB_W   = 10,
  parameter int ITER_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  engStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   srcAddrIn,
  input  logic [ADDR_W-1:0]   dstAddrIn,
  input  logic [OFF_W-1:0]    srcOff,
  input  logic [OFF_W-1:0]    dstOff,
  input  logic [1:0]          srcSize,
  input  logic [1:0]          dstSize,
  input  logic [NB_W-1:0]     minorBytes,
  input  logic [ITER_W-1:0]   citerIn,
  input  logic [ITER_W-1:0]   biterIn,
  input  logic [DATA_W-1:0]   rdData,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic [DATA_W/8-1:0] wrBe,
  output logic [ITER_W-1:0]   citer,
  output logic                packWillFill,
  output logic                minorDone,
  output logic                lastIter
);

  localparam int LANES = DATA_W / 8;
  localparam int CW    = $clog2(LANES) + 2;

  logic [ADDR_W-1:0] srcA, dstA;
  logic [NB_W-1:0]   bytesLeft;
  logic [ITER_W-1:0] citerQ;
  logic              armed;
  logic [DATA_W-1:0] packBuf;
  logic [CW-1:0]     packCnt;
  logic [CW-1:0]     srcBytes, dstBytes;
  logic [DATA_W-1:0] srcMask;
  logic [ADDR_W-1:0] srcStep, dstStep;

  assign srcBytes = CW'(1) << srcSize;
  assign dstBytes = CW'(1) << dstSize;
  assign srcStep  = {{(ADDR_W-OFF_W){srcOff[OFF_W-1]}}, srcOff};
  assign dstStep  = {{(ADDR_W-OFF_W){dstOff[OFF_W-1]}}, dstOff};

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign srcMask[b*8 +: 8] = (CW'(b) < srcBytes) ? 8'hFF : 8'h00;
    assign wrBe[b]           = (CW'(b) < dstBytes);
  end

  assign packWillFill = (packCnt + srcBytes) >= dstBytes;
  assign minorDone    = (bytesLeft == '0);
  assign lastIter     = (citerQ == ITER_W'(1));
  assign rdAddr       = srcA;
  assign wrAddr       = dstA;
  assign wrData       = packBuf;
  assign citer        = citerQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcA      <= '0;
      dstA      <= '0;
      bytesLeft <= '0;
      citerQ    <= '0;
      armed     <= 1'b0;
      packBuf   <= '0;
      packCnt   <= '0;
    end else begin
      if (strobe.load) begin
        if (!armed) begin
          srcA   <= srcAddrIn;
          dstA   <= dstAddrIn;
          citerQ <= citerIn;
        end
        armed     <= 1'b1;
        bytesLeft <= minorBytes;
        packBuf   <= '0;
        packCnt   <= '0;
      end
      if (strobe.issueRd) srcA <= srcA + srcStep;
      if (strobe.capture) begin
        packBuf   <= packBuf | ((rdData & srcMask) << {packCnt, 3'b000});
        packCnt   <= packCnt + srcBytes;
        bytesLeft <= bytesLeft - NB_W'(srcBytes);
      end
      if (strobe.issueWr) begin
        dstA    <= dstA + dstStep;
        packBuf <= '0;
        packCnt <= '0;
      end
      if (strobe.minorEnd) begin
        citerQ <= lastIter ? biterIn : citerQ - ITER_W'(1);
        armed  <= !lastIter;
      end
    end
  end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int NB_W   = 10,
  parameter int ITER_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  output logic                startAck,
  input  logic                doneClr,
  input  logic                intEn,
  input  logic [ADDR_W-1:0]   srcAddrIn,
  input  logic [ADDR_W-1:0]   dstAddrIn,
  input  logic [OFF_W-1:0]    srcOff,
  input  logic [OFF_W-1:0]    dstOff,
  input  logic [1:0]          srcSize,
  input  logic [1:0]          dstSize,
  input  logic [NB_W-1:0]     minorBytes,
  input  logic [ITER_W-1:0]   citerIn,
  input  logic [ITER_W-1:0]   biterIn,
  output logic                rdEn,
  output logic [ADDR_W-1:0]   rdAddr,
  input  logic [DATA_W-1:0]   rdData,
  output logic                wrEn,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic [DATA_W/8-1:0] wrBe,
  output logic                busy,
  output logic                done,
  output logic                irq,
  output logic [ITER_W-1:0]   citer
);

  engStrobe_t strobe;
  logic packWillFill, minorDone, lastIter;

  dma_eng_ctrl u_ctrl (
    .clk, .rstN, .startReq, .doneClr, .intEn,
    .packWillFill, .minorDone, .lastIter,
    .strobe, .startAck, .busy, .done, .irq
  );

  dma_eng_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
    .NB_W(NB_W), .ITER_W(ITER_W)
  ) u_dpath (
    .clk, .rstN, .strobe, .srcAddrIn, .dstAddrIn, .srcOff, .dstOff,
    .srcSize, .dstSize, .minorBytes, .citerIn, .biterIn, .rdData,
    .rdAddr, .wrAddr, .wrData, .wrBe, .citer,
    .packWillFill, .minorDone, .lastIter
  );

  assign rdEn = strobe.issueRd;
  assign wrEn = strobe.issueWr;

endmodule

// File: rtl/dma_eng_chk.sv
module dma_eng_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             startAck,
  input logic             busy,
  input logic             rdEn,
  input logic             wrEn,
  input logic             done,
  input logic             irq,
  input logic             doneClr,
  input logic [1:0]       dstSize,
  input logic [LANES-1:0] wrBe
);

  AST_ACK_THEN_READ: assert property (@(posedge clk) disable iff (!rstN)
    startAck |=> busy && rdEn);                                        // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdEn && !wrEn);                                         // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn));                                                  // R3
  AST_BE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $countones(wrBe) == (1 << dstSize));                      // R3
  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !busy);                                            // R6
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> done);                                                     // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    done && !doneClr && !startAck |=> done);                           // R8

endmodule

bind dma_xfer_engine dma_eng_chk #(.LANES(DATA_W/8)) u_chk (
  .clk(clk), .rstN(rstN), .startAck(startAck), .busy(busy), .rdEn(rdEn),
  .wrEn(wrEn), .done(done), .irq(irq), .doneClr(doneClr),
  .dstSize(dstSize), .wrBe(wrBe)
);

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, doneClr = 1'b0, intEn = 1'b0;
  logic [31:0] srcAddrIn = '0, dstAddrIn = '0;
  logic [15:0] srcOff = '0, dstOff = '0;
  logic [1:0]  srcSize = '0, dstSize = '0;
  logic [9:0]  minorBytes = '0;
  logic [8:0]  citerIn = '0, biterIn = '0;
  logic        startAck, rdEn, wrEn, busy, done, irq;
  logic [31:0] rdAddr, wrAddr, wrData, rdData;
  logic [3:0]  wrBe;
  logic [8:0]  citer;

  int checks = 0, errors = 0;
  logic [7:0] smem [256];
  logic [7:0] dmem [256];
  logic [7:0] emem [256];
  logic clrReq = 1'b0;

  always #2.5 clk = ~clk;

  dma_xfer_engine u_dut (.*);

  always @(posedge clk) begin
    if (rdEn) rdData <= {smem[rdAddr[7:0]+8'd3], smem[rdAddr[7:0]+8'd2],
                         smem[rdAddr[7:0]+8'd1], smem[rdAddr[7:0]]};
    if (clrReq) for (int i = 0; i < 256; i++) dmem[i] <= 8'h00;
    else if (wrEn)
      for (int b = 0; b < 4; b++)
        if (wrBe[b]) dmem[wrAddr[7:0]+8'(b)] <= wrData[b*8 +: 8];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // fields: srcSize, dstSize, srcOff, dstOff, bytes, iterations, intEn
  localparam logic [36:0] VEC [8] = '{
    {2'd0, 2'd2, 8'h01, 8'h04, 8'd16, 8'd1, 1'b1},
    {2'd0, 2'd2, 8'h01, 8'h04, 8'd8,  8'd3, 1'b0},
    {2'd1, 2'd2, 8'h02, 8'h04, 8'd8,  8'd2, 1'b1},
    {2'd2, 2'd2, 8'h04, 8'h04, 8'd12, 8'd1, 1'b1},
    {2'd0, 2'd1, 8'h01, 8'h02, 8'd6,  8'd2, 1'b1},
    {2'd0, 2'd2, 8'hFF, 8'h04, 8'd8,  8'd1, 1'b0},
    {2'd0, 2'd2, 8'h01, 8'h00, 8'd8,  8'd1, 1'b1},
    {2'd0, 2'd0, 8'h01, 8'h01, 8'd4,  8'd1, 1'b0}
  };

  task automatic activate();
    @(negedge clk) startReq = 1'b1;
    #1;
    while (!startAck) begin @(negedge clk); #1; end
    @(negedge clk) startReq = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) smem[i] = 8'(i * 7 + 3);
    #1;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 irq", irq, 0);
    check("R1 bus", {startAck, rdEn, wrEn}, 0);
    check("R1 citer", citer, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: no activity without a start
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (rdEn || wrEn || busy) begin check("R2 idle quiet", 1, 0); break; end
    end
    check("R2 idle quiet", busy, 0);

    foreach (VEC[v]) begin
      automatic int ss = VEC[v][36:35], ds = VEC[v][34:33];
      automatic int so = $signed(VEC[v][32:25]), dof = $signed(VEC[v][24:17]);
      automatic int nb = VEC[v][16:9], it = VEC[v][8:1];
      automatic int sb = 1 << ss, db = 1 << ds;
      automatic int srcBase = 32'h1040, dstBase = 32'h2000;
      @(negedge clk) clrReq = 1'b1;
      @(negedge clk) clrReq = 1'b0;
      for (int i = 0; i < 256; i++) emem[i] = 8'h00;
      for (int k = 0; k < nb * it; k++) begin
        automatic int sa = srcBase + (k / sb) * so + (k % sb);
        automatic int da = dstBase + (k / db) * dof + (k % db);
        emem[da & 255] = smem[sa & 255];
      end
      srcSize = 2'(ss); dstSize = 2'(ds);
      srcOff = 16'(so); dstOff = 16'(dof);
      minorBytes = 10'(nb); citerIn = 9'(it); biterIn = 9'(it);
      srcAddrIn = 32'(srcBase); dstAddrIn = 32'(dstBase);
      intEn = VEC[v][0];
      for (int a = 0; a < it; a++) begin
        activate();
        if (a < it - 1) begin
          check("R5 not done mid-loop", done, 0);
          check("R5 citer decrement", citer, 32'(it - a - 1));
        end
      end
      check(it == 1 ? "R9 done one activation" : "R6 done", done, 1);
      check("R7 irq gating", irq, VEC[v][0]);
      check("R6 citer reload", citer, 32'(it));
      begin
        automatic int bad = 0;
        for (int i = 0; i < 256; i++) if (dmem[i] !== emem[i]) bad++;
        check("R3 R4 destination image", bad, 0);
      end
    end

    // R8: done holds, then cleared by doneClr
    repeat (5) @(negedge clk);
    check("R8 done held", done, 1);
    doneClr = 1'b1;
    @(negedge clk) doneClr = 1'b0;
    check("R8 done cleared", done, 0);
    check("R8 irq cleared", irq, 0);

    // R8: a new start clears done; R2 ack pulse then read next cycle
    intEn = 1'b1; citerIn = 9'd1; biterIn = 9'd1;
    activate();
    check("R7 irq with enable", irq, 1);
    @(negedge clk) startReq = 1'b1;
    #1 check("R2 ack while idle", startAck, 1);
    @(negedge clk) startReq = 1'b0;
    check("R8 start clears done", done, 0);
    check("R2 read after ack", rdEn, 1);
    while (busy) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule